// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block collects a parameterised set of peripheral interrupt lines (32 by default) into one wired interrupt request for a parent interrupt controller. Each line has a pending bit. The bits are held in a cause register. Software reaches the block through a small memory-mapped port: an address, a write enable, write data and combinational read data. Four registers sit behind that port: cause, set-cause, mask and control.

A single control bit sets how every input is captured. Either all inputs are active-high level, or all are rising edge. Software acknowledges an interrupt by writing zeros into the cause register. It can re-raise a source by writing ones into set-cause. The wired request is high while any pending bit is not masked. A second control bit is only stored and read back; it has no effect inside this block.

Register offsets: cause 0x00, set-cause 0x08, mask 0x10, control 0x28. Bit n of cause, set-cause and mask belongs to input n. Control bit 3 selects rising-edge capture when 1 and level capture when 0. Control bit 5 is the stored message-disable flag.

Top module: `irq_wire_agg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the registers hold these values: cause is 0, mask is all ones, control is 0, and `irq_o` is low.
- R2: In level mode (control bit 3 = 0), an input that is high at a clock edge sets its cause bit at that edge. A clear written at the same edge does not remove it.
- R3: In edge mode (control bit 3 = 1), a cause bit is set only at an edge where its input is high and was low at the previous edge. An input that stays high does not set the bit again after it has been cleared.
- R4: A write to offset 0x00 clears every cause bit whose written bit is 0. Cause bits whose written bit is 1 keep their value. Reading offset 0x00 returns cause.
- R5: A write to offset 0x08 sets every cause bit whose written bit is 1. Written zeros change nothing. Reading offset 0x08 returns 0.
- R6: Offset 0x10 is the mask register and can be read and written. A mask bit of 1 blocks its source from `irq_o`.
- R7: `irq_o` is high exactly when some cause bit is 1 and its mask bit is 0.
- R8: Control stores only bit 3 (edge select) and bit 5 (message-disable flag). All other control bits read as 0.
- R9: When the hardware sets a cause bit and a software clear hits the same bit at the same edge, the bit ends up set.
- R10: Reads from any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NSRC | Peripheral interrupt inputs |
| addr_i | input | AW | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Wired interrupt request to the parent |

## Verification
The assertions are checked on every cycle. They cover the reset values and the zero readback of set-cause and unmapped offsets. They also check that a cause bit only appears when there is a capture or a software set. A bit only disappears when a zero is written to it. In level mode a high input always shows up in cause. A fully masked block never raises the request. Other behaviour needs the bench's sequences to show it: the clear-versus-capture priority, edge mode ignoring an input that stays high, the control bits, and unmapped writes leaving the other registers unchanged.

// File: rtl/irqagg_pkg.sv
// Package: shared constants and types for the wired interrupt aggregator.
// Assumes byte offsets on the register port; offsets fit in 6 address bits.
package irqagg_pkg;
    localparam int NSRC_DEF   = 32;
    localparam int AW_DEF     = 6;
    localparam int OFF_CAUSE  = 'h00;
    localparam int OFF_SETC   = 'h08;
    localparam int OFF_MASK   = 'h10;
    localparam int OFF_CTRL   = 'h28;
    localparam int CTRL_EDGE  = 3;
    localparam int CTRL_MSGOFF = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_SETC,
        SEL_MASK,
        SEL_CTRL
    } reg_sel_e;
endpackage

// File: rtl/irqagg_decode.sv
// Module: address decoder. Turns the register offset into a select code
// and per-register write strobes. Pure combinational; unknown offsets
// yield SEL_NONE and no strobe.
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int AW = AW_DEF
) (
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    output reg_sel_e      sel_o,
    output logic          cause_we_o,
    output logic          setc_we_o,
    output logic          mask_we_o,
    output logic          ctrl_we_o
);
    // Map offset to register select
    always_comb begin
        if (addr_i == AW'(OFF_CAUSE))      sel_o = SEL_CAUSE;
        else if (addr_i == AW'(OFF_SETC))  sel_o = SEL_SETC;
        else if (addr_i == AW'(OFF_MASK))  sel_o = SEL_MASK;
        else if (addr_i == AW'(OFF_CTRL))  sel_o = SEL_CTRL;
        else                               sel_o = SEL_NONE;
    end

    // Qualify writes per register
    always_comb begin
        cause_we_o = wr_en_i && (sel_o == SEL_CAUSE);
        setc_we_o  = wr_en_i && (sel_o == SEL_SETC);
        mask_we_o  = wr_en_i && (sel_o == SEL_MASK);
        ctrl_we_o  = wr_en_i && (sel_o == SEL_CTRL);
    end
endmodule

// File: rtl/irqagg_cfg.sv
// Module: configuration storage. Holds the mask register and the two
// implemented control bits. Assumes write data is sampled with the strobe.
module irqagg_cfg
    import irqagg_pkg::*;
#(
    parameter int NSRC = NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we_i,
    input  logic            ctrl_we_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] mask_o,
    output logic            edge_mode_o,
    output logic            msg_off_o
);
    // Mask register, resets to all blocked
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '1;
        else if (mask_we_i) mask_o <= wdata_i;
    end

    // Control bits: trigger select and stored message-disable flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_mode_o <= 1'b0;
            msg_off_o   <= 1'b0;
        end else if (ctrl_we_i) begin
            edge_mode_o <= wdata_i[CTRL_EDGE];
            msg_off_o   <= wdata_i[CTRL_MSGOFF];
        end
    end
endmodule

// File: rtl/irqagg_capture.sv
// Module: per-source capture. One cell per input holds the registered
// input and the pending bit. Hardware set has priority over software
// clear; software set is ORed in. Inputs assumed synchronous to clk.
module irqagg_capture
    import irqagg_pkg::*;
#(
    parameter int NSRC = NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_mode_i,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] set_i,
    output logic [NSRC-1:0] cause_o,
    output logic [NSRC-1:0] src_dly_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        logic dly_r;
        logic pend_r;
        logic hit;

        // Capture condition for the selected trigger mode
        always_comb hit = edge_mode_i ? (src_i[i] & ~dly_r) : src_i[i];

        // Input delay stage and pending bit update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_r  <= 1'b0;
                pend_r <= 1'b0;
            end else begin
                dly_r  <= src_i[i];
                pend_r <= (pend_r & ~clr_i[i]) | hit | set_i[i];
            end
        end

        assign cause_o[i]   = pend_r;
        assign src_dly_o[i] = dly_r;
    end
endmodule

// File: rtl/irq_wire_agg.sv
// Module: top of the wired interrupt aggregator. Ties decode, config and
// capture together, forms the read data and the wired request.
// Assumes NSRC > CTRL_MSGOFF so control bits fit the data word.
module irq_wire_agg
    import irqagg_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int AW   = AW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [AW-1:0]   addr_i,
    input  logic            wr_en_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] rdata_o,
    output logic            irq_o
);
    reg_sel_e        sel;
    logic            cause_we, setc_we, mask_we, ctrl_we;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] cause_q;
    logic [NSRC-1:0] src_dly;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] set_vec;
    logic            edge_mode;
    logic            msg_off;

    irqagg_decode #(.AW(AW)) dec_i (
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .sel_o      (sel),
        .cause_we_o (cause_we),
        .setc_we_o  (setc_we),
        .mask_we_o  (mask_we),
        .ctrl_we_o  (ctrl_we)
    );

    irqagg_cfg #(.NSRC(NSRC)) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_we_i   (mask_we),
        .ctrl_we_i   (ctrl_we),
        .wdata_i     (wdata_i),
        .mask_o      (mask_q),
        .edge_mode_o (edge_mode),
        .msg_off_o   (msg_off)
    );

    // Software clear (zeros written to cause) and software set vectors
    always_comb begin
        clr_vec = cause_we ? ~wdata_i : '0;
        set_vec = setc_we  ?  wdata_i : '0;
    end

    irqagg_capture #(.NSRC(NSRC)) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_mode_i (edge_mode),
        .src_i       (src_i),
        .clr_i       (clr_vec),
        .set_i       (set_vec),
        .cause_o     (cause_q),
        .src_dly_o   (src_dly)
    );

    // Read data mux; set-cause and unmapped offsets read zero
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_CAUSE: rdata_o = cause_q;
            SEL_MASK:  rdata_o = mask_q;
            SEL_CTRL: begin
                rdata_o[CTRL_EDGE]   = edge_mode;
                rdata_o[CTRL_MSGOFF] = msg_off;
            end
            default:   rdata_o = '0;
        endcase
    end

    // Wired request: any unmasked pending source
    always_comb irq_o = |(cause_q & ~mask_q);
endmodule

// File: rtl/irqagg_chk.sv
// Module: assertion checker for irq_wire_agg, attached with bind.
// Observes ports plus the cause, mask, mode and delayed-input state.
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int AW   = AW_DEF
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic [AW-1:0]   addr_i,
    input logic            wr_en_i,
    input logic [NSRC-1:0] wdata_i,
    input logic [NSRC-1:0] rdata_o,
    input logic            irq_o,
    input logic [NSRC-1:0] cause_q,
    input logic [NSRC-1:0] mask_q,
    input logic            edge_mode,
    input logic [NSRC-1:0] src_dly
);
    logic            setc_wr, cause_wr;
    logic [NSRC-1:0] capt;
    always_comb begin
        setc_wr  = wr_en_i && (addr_i == AW'(OFF_SETC));
        cause_wr = wr_en_i && (addr_i == AW'(OFF_CAUSE));
        capt     = edge_mode ? (src_i & ~src_dly) : src_i;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cause_q == '0 && mask_q == '1 && !edge_mode && !irq_o));

    // R2
    level_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(edge_mode)) |-> ((cause_q & $past(src_i)) == $past(src_i)));

    // R3
    new_pending_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cause_q & ~$past(cause_q) &
            ~($past(capt) | $past(setc_wr ? wdata_i : '0))) == '0));

    // R4
    clear_by_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~cause_q & $past(cause_q) &
            ~$past(cause_wr ? ~wdata_i : '0)) == '0));

    // R5
    setc_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == AW'(OFF_SETC)) |-> (rdata_o == '0));

    // R6
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);

    // R10
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != AW'(OFF_CAUSE) && addr_i != AW'(OFF_MASK) &&
         addr_i != AW'(OFF_CTRL)) |-> (rdata_o == '0));
endmodule

bind irq_wire_agg irqagg_chk #(.NSRC(NSRC), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .edge_mode (edge_mode),
    .src_dly   (src_dly)
);

// File: tb/irq_wire_agg_tb_top.sv
// Bench: vector table walked by one loop, then directed reset checks.
module irq_wire_agg_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 22;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [31:0] src;
        logic [5:0]  raddr;
        logic [31:0] exp;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'h10, 32'hFFFF0000, 32'h0,   6'h10, 32'hFFFF0000, 1'b0, 8'd6},  // R6
        '{1'b0, 6'h00, 32'h0,        32'h5,   6'h00, 32'h5,        1'b1, 8'd2},  // R2
        '{1'b1, 6'h00, 32'h0,        32'h5,   6'h00, 32'h5,        1'b1, 8'd2},  // R2
        '{1'b1, 6'h00, 32'h0,        32'h0,   6'h00, 32'h0,        1'b0, 8'd4},  // R4
        '{1'b1, 6'h08, 32'h00010002, 32'h0,   6'h00, 32'h00010002, 1'b1, 8'd5},  // R5
        '{1'b0, 6'h08, 32'h0,        32'h0,   6'h08, 32'h0,        1'b1, 8'd5},  // R5
        '{1'b1, 6'h00, 32'hFFFFFFFD, 32'h0,   6'h00, 32'h00010000, 1'b0, 8'd4},  // R4
        '{1'b1, 6'h10, 32'h0,        32'h0,   6'h10, 32'h0,        1'b1, 8'd7},  // R7
        '{1'b1, 6'h10, 32'hFFFFFFFF, 32'h0,   6'h00, 32'h00010000, 1'b0, 8'd7},  // R7
        '{1'b1, 6'h00, 32'h0,        32'h0,   6'h00, 32'h0,        1'b0, 8'd4},  // R4
        '{1'b1, 6'h28, 32'hFFFFFFFF, 32'h0,   6'h28, 32'h28,       1'b0, 8'd8},  // R8
        '{1'b1, 6'h28, 32'h00000008, 32'h0,   6'h28, 32'h08,       1'b0, 8'd8},  // R8
        '{1'b1, 6'h10, 32'h0,        32'h100, 6'h00, 32'h100,      1'b1, 8'd3},  // R3
        '{1'b1, 6'h00, 32'h0,        32'h100, 6'h00, 32'h0,        1'b0, 8'd3},  // R3
        '{1'b0, 6'h00, 32'h0,        32'h100, 6'h00, 32'h0,        1'b0, 8'd3},  // R3
        '{1'b0, 6'h00, 32'h0,        32'h0,   6'h00, 32'h0,        1'b0, 8'd3},  // R3
        '{1'b1, 6'h00, 32'h0,        32'h100, 6'h00, 32'h100,      1'b1, 8'd9},  // R9
        '{1'b1, 6'h3C, 32'hFFFFFFFF, 32'h100, 6'h3C, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b0, 6'h00, 32'h0,        32'h100, 6'h10, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b1, 6'h28, 32'h00000020, 32'h100, 6'h28, 32'h20,       1'b1, 8'd8},  // R8
        '{1'b1, 6'h18, 32'h0,        32'h0,   6'h00, 32'h100,      1'b1, 8'd10}, // R10
        '{1'b1, 6'h08, 32'h0,        32'h0,   6'h00, 32'h100,      1'b1, 8'd5}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_wire_agg dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .addr_i  (addr),
        .wr_en_i (wr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_chk("R1 cause", 6'h00, 32'h0);
        read_chk("R1 mask", 6'h10, 32'hFFFFFFFF);
        read_chk("R1 ctrl", 6'h28, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            src   = VEC[i].src;
            addr  = VEC[i].addr;
            wr    = VEC[i].wr;
            wdata = VEC[i].wdata;
            @(posedge clk);
            @(negedge clk);
            wr = 1'b0;
            read_chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), VEC[i].raddr, VEC[i].exp);
            check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
        end

        // R1: reset mid-run restores every register
        src = '0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_chk("R1 cause after rerun", 6'h00, 32'h0);
        read_chk("R1 mask after rerun", 6'h10, 32'hFFFFFFFF);
        read_chk("R1 ctrl after rerun", 6'h28, 32'h0);
        check("R1 irq after rerun", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule